// File: doc/BRIEF.md
# Operand Bypass and Pipeline Interlock Controller

This block is the combinational interlock logic of a five-stage in-order integer pipeline. It looks at the register numbers carried by the instructions in Decode, Execute, Memory and Writeback, and at a few control bits. From these it decides three things. The first is whether each ALU operand in Execute should take a newer result from a later stage instead of the register-file value. The second is whether the front of the pipeline must hold for one cycle because a load feeds the next instruction. The third is which pipeline registers must be cleared when a taken branch or jump sends fetch to a new address.

The surrounding datapath decodes each bypass select. A select of `2'b10` picks the Memory-stage ALU result, `2'b01` picks the Writeback result, and `2'b00` keeps the register-file read. The datapath also uses the hold outputs to freeze the PC and the Fetch/Decode register, and the squash outputs to turn a pipeline register into a no-op. A taken redirect clears the two younger instructions, so it costs two cycles. A load-use dependency costs one cycle. The block holds no state, and every output follows its inputs within the same cycle.

Top module: `hazard_ctrl`

## Requirements
- R1: `ex_byp_a` is `2'b10` when `ex_src1` equals `mem_dst`, `mem_wr_en` is 1 and `ex_src1` is nonzero.
- R2: Otherwise `ex_byp_a` is `2'b01` when `ex_src1` equals `wb_dst`, `wb_wr_en` is 1 and `ex_src1` is nonzero. In every other case it is `2'b00`.
- R3: When the Memory and Writeback match conditions both hold for an operand, the Memory select `2'b10` is chosen.
- R4: `ex_byp_b` follows the rules of R1 to R3, using `ex_src2` in place of `ex_src1`.
- R5: An operand whose source register number is 0 always gets select `2'b00`, even when a later stage writes register 0.
- R6: A stage whose write enable is 0 never produces a bypass, even when its destination number matches.
- R7: `hold_fetch` and `hold_decode` are both 1 exactly when `ex_is_load` is 1 and `dec_src1` or `dec_src2` equals `ex_dst`.
- R8: When `ex_is_load` is 0, neither hold output is asserted, whatever the register numbers.
- R9: The load-use comparison also applies to register 0. A load to register 0 followed by a reader of register 0 asserts the holds.
- R10: `squash_decode` equals `ex_redirect`.
- R11: `squash_execute` is 1 when the load-use hold is active or `ex_redirect` is 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_src1 | input | 5 | First source register of the instruction in Decode |
| dec_src2 | input | 5 | Second source register of the instruction in Decode |
| ex_src1 | input | 5 | First source register of the instruction in Execute |
| ex_src2 | input | 5 | Second source register of the instruction in Execute |
| ex_dst | input | 5 | Destination register of the instruction in Execute |
| mem_dst | input | 5 | Destination register of the instruction in Memory |
| wb_dst | input | 5 | Destination register of the instruction in Writeback |
| mem_wr_en | input | 1 | Instruction in Memory will write the register file |
| wb_wr_en | input | 1 | Instruction in Writeback will write the register file |
| ex_is_load | input | 1 | Instruction in Execute takes its result from data memory |
| ex_redirect | input | 1 | Branch taken or jump in Execute |
| ex_byp_a | output | 2 | Bypass select for ALU operand A |
| ex_byp_b | output | 2 | Bypass select for ALU operand B |
| hold_fetch | output | 1 | Keep the PC unchanged |
| hold_decode | output | 1 | Keep the Fetch/Decode register unchanged |
| squash_decode | output | 1 | Clear the Fetch/Decode register |
| squash_execute | output | 1 | Clear the Decode/Execute register |

## Verification
Every result of this block is due in the same cycle as its stimulus, with zero register delay from any input to any output. The driver applies each stimulus just after a rising edge and queues the expected outputs. The monitor compares them at the following falling edge, half a period later, once the logic has settled and before the next stimulus arrives. The queue therefore never holds more than one item.

// File: rtl/hazard_pkg.sv
// Package: hazard_pkg
// Shared types for the interlock controller. The bypass select encoding is
// decoded by the Execute-stage operand muxes, so its values are fixed.
package hazard_pkg;
    typedef enum logic [1:0] {
        BYP_RF  = 2'b00,
        BYP_WB  = 2'b01,
        BYP_MEM = 2'b10
    } byp_sel_e;
endpackage

// File: rtl/byp_select.sv
// Module: byp_select
// Picks the bypass source for one Execute operand. Assumes the register 0
// is hard-wired to zero, so it must never be bypassed. Memory beats Writeback.
module byp_select
    import hazard_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] mem_dst,
    input  logic [AW-1:0] wb_dst,
    input  logic          mem_wr_en,
    input  logic          wb_wr_en,
    output logic [1:0]    sel
);
    logic src_live;
    logic hit_mem;
    logic hit_wb;

    // Match each later stage against the operand's source number.
    always_comb begin
        src_live = (src != '0);
        hit_mem  = src_live && mem_wr_en && (src == mem_dst);
        hit_wb   = src_live && wb_wr_en  && (src == wb_dst);
    end

    // Priority pick: the newer Memory result wins over Writeback.
    always_comb begin
        if (hit_mem)     sel = BYP_MEM;
        else if (hit_wb) sel = BYP_WB;
        else             sel = BYP_RF;
    end
endmodule

// File: rtl/load_use_detect.sv
// Module: load_use_detect
// Flags a Decode instruction that reads the destination of a load sitting in
// Execute. Register 0 is deliberately not excluded; the stall is harmless.
module load_use_detect #(
    parameter int AW     = 5,
    parameter int NSRC   = 2
) (
    input  logic [NSRC*AW-1:0] dec_srcs,
    input  logic [AW-1:0]      ex_dst,
    input  logic               ex_is_load,
    output logic               stall
);
    logic [NSRC-1:0] hit;

    // One comparator per Decode source operand.
    for (genvar i = 0; i < NSRC; i++) begin : g_cmp
        assign hit[i] = (dec_srcs[i*AW +: AW] == ex_dst);
    end

    // Stall only when a load is the producer.
    always_comb stall = ex_is_load && (|hit);
endmodule

// File: rtl/squash_ctrl.sv
// Module: squash_ctrl
// Turns the load-use stall and a taken redirect into hold and clear controls.
// Assumes a redirect resolved in Execute discards exactly two younger slots.
module squash_ctrl (
    input  logic stall,
    input  logic redirect,
    output logic hold_f,
    output logic hold_d,
    output logic clr_d,
    output logic clr_e
);
    // Holds freeze the front end; clears insert bubbles.
    always_comb begin
        hold_f = stall;
        hold_d = stall;
        clr_d  = redirect;
        clr_e  = stall | redirect;
    end
endmodule

// File: rtl/hazard_ctrl.sv
// Module: hazard_ctrl
// Top of the interlock controller: two operand bypass selectors, a load-use
// detector and the squash logic. Purely combinational, holds no state.
module hazard_ctrl
    import hazard_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] dec_src1,
    input  logic [AW-1:0] dec_src2,
    input  logic [AW-1:0] ex_src1,
    input  logic [AW-1:0] ex_src2,
    input  logic [AW-1:0] ex_dst,
    input  logic [AW-1:0] mem_dst,
    input  logic [AW-1:0] wb_dst,
    input  logic          mem_wr_en,
    input  logic          wb_wr_en,
    input  logic          ex_is_load,
    input  logic          ex_redirect,
    output logic [1:0]    ex_byp_a,
    output logic [1:0]    ex_byp_b,
    output logic          hold_fetch,
    output logic          hold_decode,
    output logic          squash_decode,
    output logic          squash_execute
);
    localparam int NOPS = 2;

    logic [NOPS*AW-1:0] ex_srcs;
    logic [NOPS*AW-1:0] dec_srcs;
    logic [NOPS*2-1:0]  sels;
    logic               lu_stall;

    // Pack the operand numbers so the replicated logic can index them.
    always_comb begin
        ex_srcs  = {ex_src2, ex_src1};
        dec_srcs = {dec_src2, dec_src1};
    end

    for (genvar i = 0; i < NOPS; i++) begin : g_op
        byp_select #(.AW(AW)) u_sel (
            .src       (ex_srcs[i*AW +: AW]),
            .mem_dst   (mem_dst),
            .wb_dst    (wb_dst),
            .mem_wr_en (mem_wr_en),
            .wb_wr_en  (wb_wr_en),
            .sel       (sels[i*2 +: 2])
        );
    end

    // Route the per-operand selects to their ports.
    always_comb begin
        ex_byp_a = sels[1:0];
        ex_byp_b = sels[3:2];
    end

    load_use_detect #(.AW(AW), .NSRC(NOPS)) u_lu (
        .dec_srcs   (dec_srcs),
        .ex_dst     (ex_dst),
        .ex_is_load (ex_is_load),
        .stall      (lu_stall)
    );

    squash_ctrl u_sq (
        .stall    (lu_stall),
        .redirect (ex_redirect),
        .hold_f   (hold_fetch),
        .hold_d   (hold_decode),
        .clr_d    (squash_decode),
        .clr_e    (squash_execute)
    );
endmodule

// File: rtl/hazard_ctrl_chk.sv
// Module: hazard_ctrl_chk
// Port-level consistency checks on the controller, bound into every instance.
module hazard_ctrl_chk #(
    parameter int AW = 5
) (
    input logic [AW-1:0] dec_src1,
    input logic [AW-1:0] dec_src2,
    input logic [AW-1:0] ex_src1,
    input logic [AW-1:0] ex_dst,
    input logic [AW-1:0] mem_dst,
    input logic          mem_wr_en,
    input logic          wb_wr_en,
    input logic          ex_is_load,
    input logic          ex_redirect,
    input logic [1:0]    ex_byp_a,
    input logic [1:0]    ex_byp_b,
    input logic          hold_fetch,
    input logic          hold_decode,
    input logic          squash_decode,
    input logic          squash_execute
);
    // Settled-value checks relating outputs to each other and to inputs.
    always_comb begin
        assert_sel_legal_R4: assert (ex_byp_a != 2'b11 && ex_byp_b != 2'b11);
        assert_mem_sel_cause_R1: assert (ex_byp_a != 2'b10 ||
            (mem_wr_en && ex_src1 == mem_dst && ex_src1 != '0));
        assert_wb_sel_enable_R6: assert (ex_byp_a != 2'b01 || wb_wr_en);
        assert_zero_src_R5: assert (ex_src1 != '0 || ex_byp_a == 2'b00);
        assert_holds_agree_R7: assert (hold_fetch == hold_decode);
        assert_hold_needs_load_R8: assert (ex_is_load || !hold_fetch);
        assert_hold_needs_match_R7: assert (!hold_fetch ||
            dec_src1 == ex_dst || dec_src2 == ex_dst);
        assert_redirect_clear_R10: assert (squash_decode == ex_redirect);
        assert_clear_e_cover_R11: assert (squash_execute ==
            (hold_decode || squash_decode));
    end
endmodule

bind hazard_ctrl hazard_ctrl_chk #(.AW(AW)) u_chk (
    .dec_src1       (dec_src1),
    .dec_src2       (dec_src2),
    .ex_src1        (ex_src1),
    .ex_dst         (ex_dst),
    .mem_dst        (mem_dst),
    .mem_wr_en      (mem_wr_en),
    .wb_wr_en       (wb_wr_en),
    .ex_is_load     (ex_is_load),
    .ex_redirect    (ex_redirect),
    .ex_byp_a       (ex_byp_a),
    .ex_byp_b       (ex_byp_b),
    .hold_fetch     (hold_fetch),
    .hold_decode    (hold_decode),
    .squash_decode  (squash_decode),
    .squash_execute (squash_execute)
);

// File: tb/test_hazard_ctrl.sv
// Bench: scoreboard. The driver applies a stimulus after a rising edge and
// queues the expected outputs; the monitor compares at the falling edge.
module test_hazard_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [4:0] dec_src1, dec_src2, ex_src1, ex_src2, ex_dst, mem_dst, wb_dst;
    logic       mem_wr_en, wb_wr_en, ex_is_load, ex_redirect;
    logic [1:0] ex_byp_a, ex_byp_b;
    logic       hold_fetch, hold_decode, squash_decode, squash_execute;

    hazard_ctrl i_hazard_ctrl (
        .dec_src1(dec_src1), .dec_src2(dec_src2),
        .ex_src1(ex_src1), .ex_src2(ex_src2), .ex_dst(ex_dst),
        .mem_dst(mem_dst), .wb_dst(wb_dst),
        .mem_wr_en(mem_wr_en), .wb_wr_en(wb_wr_en),
        .ex_is_load(ex_is_load), .ex_redirect(ex_redirect),
        .ex_byp_a(ex_byp_a), .ex_byp_b(ex_byp_b),
        .hold_fetch(hold_fetch), .hold_decode(hold_decode),
        .squash_decode(squash_decode), .squash_execute(squash_execute)
    );

    typedef struct {
        logic [9:0] exp;
        string      tag;
    } item_t;

    item_t q[$];
    int    n_run  = 0;
    int    n_fail = 0;
    bit    done   = 0;

    // Requirement model of one operand's bypass select (R1..R6).
    function automatic logic [1:0] want_sel(logic [4:0] s, logic [4:0] md,
            logic [4:0] wd, logic mw, logic ww);
        if (s == 5'd0)            return 2'b00;
        if (mw && s == md)        return 2'b10;
        if (ww && s == wd)        return 2'b01;
        return 2'b00;
    endfunction

    // Driver: apply one stimulus and queue what the requirements predict.
    task automatic send(input logic [4:0] d1, d2, e1, e2, ed, md, wd,
                        input logic mw, ww, ld, rd, input string tag);
        item_t it;
        logic  st;
        @(posedge clk);
        #1;
        dec_src1 = d1; dec_src2 = d2; ex_src1 = e1; ex_src2 = e2;
        ex_dst = ed; mem_dst = md; wb_dst = wd;
        mem_wr_en = mw; wb_wr_en = ww; ex_is_load = ld; ex_redirect = rd;
        st = ld && (d1 == ed || d2 == ed);
        it.exp = {want_sel(e1, md, wd, mw, ww), want_sel(e2, md, wd, mw, ww),
                  st, st, rd, st | rd};
        it.tag = tag;
        q.push_back(it);
    endtask

    // Monitor: compare settled outputs half a period after the stimulus.
    always @(negedge clk) begin
        if (rst_n && q.size() > 0) begin
            item_t it;
            logic [9:0] act;
            it  = q.pop_front();
            act = {ex_byp_a, ex_byp_b, hold_fetch, hold_decode,
                   squash_decode, squash_execute};
            n_run++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %b expected %b", it.tag, act, it.exp);
            end
        end
    end

    // Watchdog: a hung run counts as one failure and still reports.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        {dec_src1, dec_src2, ex_src1, ex_src2, ex_dst, mem_dst, wb_dst} = '0;
        {mem_wr_en, wb_wr_en, ex_is_load, ex_redirect} = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // idle state: nothing bypassed, held or cleared
        send(0,0,0,0,0,0,0, 0,0,0,0, "R2 idle");
        // R1: operand A from Memory
        send(1,2,5,6,9,5,7, 1,1,0,0, "R1 mem to A");
        // R2: operand A from Writeback only
        send(1,2,7,6,9,5,7, 1,1,0,0, "R2 wb to A");
        // add/or/sub: B matches Writeback only -> B=01, A=00 (R4)
        send(3,4,19,24,0,23,24, 1,1,0,0, "R4 sub after add");
        // R3: both stages match, Memory wins on both operands
        send(1,2,8,8,9,8,8, 1,1,0,0, "R3 priority");
        // R4: operand B from Memory
        send(1,2,3,12,9,12,12, 1,0,0,0, "R4 mem to B");
        // R5: register 0 never bypassed
        send(1,2,0,0,9,0,0, 1,1,0,0, "R5 zero src");
        // R6: matching but disabled stages give no bypass
        send(1,2,11,11,9,11,11, 0,0,0,0, "R6 no write");
        // R6: Memory disabled, Writeback enabled -> Writeback used
        send(1,2,11,11,9,11,11, 0,1,0,0, "R6 mem off");
        // R7: load-use via first and second Decode source
        send(14,2,1,1,14,0,0, 0,0,1,0, "R7 src1 hit");
        send(3,14,1,1,14,0,0, 0,0,1,0, "R7 src2 hit");
        // R7: load with no dependency -> no hold
        send(3,4,1,1,14,0,0, 0,0,1,0, "R7 no hit");
        // R8: matching register but not a load
        send(14,14,1,1,14,0,0, 0,0,0,0, "R8 not load");
        // R9: load to register 0 followed by reader of register 0
        send(0,5,1,1,0,0,0, 0,0,1,0, "R9 zero load");
        // R10: redirect clears Decode and Execute
        send(3,4,1,1,9,0,0, 0,0,0,1, "R10 redirect");
        // R11: redirect together with load-use
        send(9,4,1,1,9,0,0, 0,0,1,1, "R11 both");
        // mixed: bypass and stall in the same cycle
        send(9,4,5,7,9,5,7, 1,1,1,0, "R11 mixed");
        @(posedge clk);
        @(negedge clk);
        #1;
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule